// File: doc/BRIEF.md
# Class-Index Argmax Stage with Stream Output

This block sits at the tail of a hardware classifier. Each time the scoring logic presents a full set of signed class scores with a valid strobe, the block picks the class whose score is largest and queues that class number in a small on-chip buffer. A drain stage presents queued class numbers, one per beat, on an AXI4-Stream master port, so that a DMA engine can carry the results back to memory.

Results are grouped into batches whose record count is programmed on an input. The stream marks the beat that completes each batch. A flag tells the record-feeding stage whether the buffer has room for a whole batch, which lets that stage hold off before it starts one. A write that finds the buffer full is discarded and recorded in a sticky error flag.

Top module: `argmax_stream_out`

## Requirements
- R1: For each accepted score set the emitted class number is the position (0 to 15) of the largest score, comparing scores as two's-complement signed values; position j occupies bits [16*j+15:16*j] of the score bus.
- R2: When several scores share the largest value, the lowest position among them is emitted.
- R3: A score set sampled with score_valid high on a rising edge makes m_tvalid high after the fourth following rising edge when the buffer was empty, and not earlier.
- R4: Score sets may arrive on consecutive cycles; every accepted set yields exactly one beat and beats leave in arrival order.
- R5: m_tdata carries the class number in its low 4 bits with bits 31:4 zero; while m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata does not change.
- R6: m_tlast is high on the beat that completes batch_len beats since reset or since the previous last beat; batch_len values 0 and 1 both mark every beat as last.
- R7: space_ok is high exactly when the number of free buffer entries (64 minus the entries held) is at least batch_len.
- R8: The buffer holds 64 entries; a result arriving while all 64 are held is dropped without disturbing the held entries, and overflow goes high and stays high until reset.
- R9: After reset m_tvalid is low, overflow is low, the buffer is empty and the batch beat count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| batch_len | input | 16 | Records per batch |
| score_valid | input | 1 | Score bus holds a new set this cycle |
| scores | input | 256 | Sixteen signed 16-bit scores, position j at bits 16*j+15:16*j |
| space_ok | output | 1 | Buffer can absorb a whole batch |
| overflow | output | 1 | Sticky: a result was dropped on a full buffer |
| m_tvalid | output | 1 | Stream beat available |
| m_tready | input | 1 | Stream sink accepts the beat |
| m_tdata | output | 32 | Zero-extended class number |
| m_tlast | output | 1 | Beat completes the batch |

## Verification
Assertions watch, on every cycle, that a stalled beat keeps its valid and data, that the held count rises by one on a lone accepted write, that a full buffer stays full under a write without a read, that the overflow flag never falls, and that the beat counter restarts after a last beat. Only the directed scenarios can show that the right class wins for a given score pattern including ties and extreme values, the exact four-edge latency, the batch boundaries for several batch lengths, the space flag's threshold at one entry either side, and that exactly the first 64 results survive an overflow.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/argmax_tree.sv
module argmax_tree
   import argmax_pkg::*;
#(
   parameter int N_IN = 16,
   parameter int VAL_W = 16,
   localparam int IW = $clog2(N_IN),
   localparam int LEVELS = $clog2(N_IN)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [N_IN*VAL_W-1:0]  in_vals,
   output logic                   out_valid,
   output logic [IW-1:0]          out_idx
);
   if (!is_pow2(N_IN) || N_IN < 2) begin : g_bad_n
      $error("argmax_tree: N_IN must be a power of two of at least 2");
   end

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int NODES = N_IN >> l;
      logic signed [VAL_W-1:0] v  [NODES];
      logic        [IW-1:0]    ix [NODES];
      logic                    vld;
      if (l == 0) begin : g_leaf
         for (genvar j = 0; j < NODES; j++) begin : g_in
            assign v[j]  = in_vals[j*VAL_W +: VAL_W];
            assign ix[j] = IW'(j);
         end
         assign vld = in_valid;
      end else begin : g_cmp
         for (genvar j = 0; j < NODES; j++) begin : g_node
            logic take_hi;
            // strict compare: equal values keep the lower-position entry
            assign take_hi = g_lvl[l-1].v[2*j+1] > g_lvl[l-1].v[2*j];
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  v[j]  <= '0;
                  ix[j] <= '0;
               end else begin
                  v[j]  <= take_hi ? g_lvl[l-1].v[2*j+1]  : g_lvl[l-1].v[2*j];
                  ix[j] <= take_hi ? g_lvl[l-1].ix[2*j+1] : g_lvl[l-1].ix[2*j];
               end
            end
         end
         always_ff @(posedge clk) begin
            if (!rst_n) vld <= 1'b0;
            else        vld <= g_lvl[l-1].vld;
         end
      end
   end

   assign out_valid = g_lvl[LEVELS].vld;
   assign out_idx   = g_lvl[LEVELS].ix[0];
endmodule

// File: rtl/idx_fifo.sv
module idx_fifo
   import argmax_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DATA_W = 4,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full,
   output logic [CW-1:0]     count,
   output logic              overflow
);
   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("idx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic              push, pop;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign push  = wr_en && !full;
   assign pop   = rd_en && !empty;
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
         if (wr_en && full) overflow <= 1'b1;
      end
   end

   // R4: a write without a read adds exactly one entry
   a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + CW'(1)));
   // R8: a write into a full buffer without a read leaves it full
   a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> full);
   // R8: the drop flag never clears outside reset
   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R8: held count never exceeds the depth
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/stream_emitter.sv
module stream_emitter #(
   parameter int IDX_W = 4,
   parameter int TDATA_W = 32,
   parameter int BATCH_W = 16,
   localparam int EW = BATCH_W + 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BATCH_W-1:0] batch_len,
   input  logic               src_empty,
   input  logic [IDX_W-1:0]   src_head,
   output logic               src_pop,
   output logic               tvalid,
   input  logic               tready,
   output logic [TDATA_W-1:0] tdata,
   output logic               tlast
);
   if (TDATA_W <= IDX_W) begin : g_bad_w
      $error("stream_emitter: TDATA_W must exceed IDX_W");
   end

   logic [BATCH_W-1:0] beat_cnt;
   logic               fire;

   assign tvalid  = !src_empty;
   assign tdata   = {{(TDATA_W-IDX_W){1'b0}}, src_head};
   assign tlast   = (EW'(beat_cnt) + EW'(1)) >= EW'(batch_len);
   assign fire    = tvalid && tready;
   assign src_pop = fire;

   always_ff @(posedge clk) begin
      if (!rst_n)      beat_cnt <= '0;
      else if (fire)   beat_cnt <= tlast ? '0 : beat_cnt + BATCH_W'(1);
   end

   // R5: a stalled beat keeps its valid and its payload
   a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && !tready) |=> (tvalid && $stable(tdata)));
   // R6: the beat count restarts after a batch-closing beat
   a_r6_batch_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && tlast) |=> (beat_cnt == '0));
endmodule

// File: rtl/argmax_stream_out.sv
module argmax_stream_out
   import argmax_pkg::*;
#(
   parameter int N_SCORES = 16,
   parameter int SCORE_W = 16,
   parameter int FIFO_DEPTH = 64,
   parameter int BATCH_W = 16,
   parameter int TDATA_W = 32,
   localparam int IDX_W = $clog2(N_SCORES),
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [BATCH_W-1:0]          batch_len,
   input  logic                        score_valid,
   input  logic [N_SCORES*SCORE_W-1:0] scores,
   output logic                        space_ok,
   output logic                        overflow,
   output logic                        m_tvalid,
   input  logic                        m_tready,
   output logic [TDATA_W-1:0]          m_tdata,
   output logic                        m_tlast
);
   if (BATCH_W >= 32 || BATCH_W < 1) begin : g_bad_batch
      $error("argmax_stream_out: BATCH_W must lie in 1..31");
   end

   logic             res_valid;
   logic [IDX_W-1:0] res_idx;
   logic [IDX_W-1:0] q_head;
   logic             q_empty, q_full, q_pop;
   logic [CNT_W-1:0] q_count;
   logic [31:0]      free_slots;

   argmax_tree #(.N_IN(N_SCORES), .VAL_W(SCORE_W)) u_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (score_valid),
      .in_vals   (scores),
      .out_valid (res_valid),
      .out_idx   (res_idx)
   );

   idx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(IDX_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (res_valid),
      .wr_data  (res_idx),
      .rd_en    (q_pop),
      .head     (q_head),
      .empty    (q_empty),
      .full     (q_full),
      .count    (q_count),
      .overflow (overflow)
   );

   stream_emitter #(.IDX_W(IDX_W), .TDATA_W(TDATA_W), .BATCH_W(BATCH_W)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .batch_len (batch_len),
      .src_empty (q_empty),
      .src_head  (q_head),
      .src_pop   (q_pop),
      .tvalid    (m_tvalid),
      .tready    (m_tready),
      .tdata     (m_tdata),
      .tlast     (m_tlast)
   );

   assign free_slots = 32'(FIFO_DEPTH) - 32'(q_count);
   assign space_ok   = free_slots >= 32'(batch_len);

   // R9: stream valid only ever follows a non-empty buffer; full buffer implies valid
   a_r9_full_means_valid: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> m_tvalid);
endmodule

// File: tb/tb_argmax_stream_out.sv
module tb_argmax_stream_out;
   localparam int N = 16;
   localparam int W = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [15:0]    batch_len = 16'd4;
   logic           score_valid = 1'b0;
   logic [N*W-1:0] scores = '0;
   logic           space_ok, overflow, m_tvalid, m_tlast;
   logic           m_tready = 1'b0;
   logic [31:0]    m_tdata;

   int n_checks = 0;
   int n_fail = 0;
   logic [31:0] got_d[$];
   bit          got_l[$];

   always #10 clk = ~clk;

   argmax_stream_out dut (
      .clk(clk), .rst_n(rst_n), .batch_len(batch_len), .score_valid(score_valid),
      .scores(scores), .space_ok(space_ok), .overflow(overflow), .m_tvalid(m_tvalid),
      .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
   );

   always @(posedge clk) begin
      if (rst_n && m_tvalid && m_tready) begin
         got_d.push_back(m_tdata);
         got_l.push_back(m_tlast);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [N*W-1:0] pat(input int kind, input int w);
      int s[N];
      logic [N*W-1:0] v;
      for (int j = 0; j < N; j++) begin
         case (kind)
            0: s[j] = j*100 - 700;
            1: s[j] = -j*50;
            2: s[j] = (j == 9) ? -1 : -1000 - j;
            3: s[j] = 42;
            4: s[j] = (j == 5 || j == 12) ? 500 : j;
            5: s[j] = (j == 14) ? 32767 : -32768;
            6: s[j] = (j == 3 || j == 4) ? -4 : -5;
            default: s[j] = (j == w) ? 1000 : j - 100;
         endcase
         v[j*W +: W] = 16'(s[j]);
      end
      return v;
   endfunction

   function automatic int ref_idx(input logic [N*W-1:0] v);
      int best = 0;
      for (int j = 1; j < N; j++)
         if ($signed(v[j*W +: W]) > $signed(v[best*W +: W])) best = j;
      return best;
   endfunction

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; score_valid = 1'b0; m_tready = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      got_d.delete(); got_l.delete();
   endtask

   task automatic put(input logic [N*W-1:0] v);
      @(negedge clk);
      score_valid = 1'b1;
      scores = v;
   endtask

   task automatic idle();
      @(negedge clk);
      score_valid = 1'b0;
   endtask

   task automatic wait_beats(input int n);
      for (int i = 0; i < 500 && got_d.size() < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      batch_len = 16'd4;
      @(negedge clk);
      chk(m_tvalid == 1'b0, "R9 tvalid after reset", int'(m_tvalid), 0);
      chk(overflow == 1'b0, "R9 overflow after reset", int'(overflow), 0);
      chk(space_ok == 1'b1, "R9 empty buffer has space", int'(space_ok), 1);
   endtask

   task automatic t_latency_stall();
      logic [31:0] held;
      do_reset();
      batch_len = 16'd4;
      put(pat(4, 0));
      idle();
      cyc(3);
      chk(m_tvalid == 1'b0, "R3 not valid after third edge", int'(m_tvalid), 0);
      cyc(1);
      chk(m_tvalid == 1'b1, "R3 valid after fourth edge", int'(m_tvalid), 1);
      chk(m_tdata == 32'd5, "R2 tie picks lower position", int'(m_tdata), 5);
      held = m_tdata;
      cyc(3);
      chk(m_tvalid == 1'b1 && m_tdata == held, "R5 stalled beat held",
          int'(m_tdata), int'(held));
      m_tready = 1'b1;
      wait_beats(1);
      chk(got_d.size() == 1, "R4 one beat per set", got_d.size(), 1);
   endtask

   task automatic t_patterns();
      logic [N*W-1:0] v[7];
      do_reset();
      batch_len = 16'd16;
      m_tready = 1'b1;
      for (int k = 0; k < 7; k++) v[k] = pat(k, 0);
      for (int k = 0; k < 7; k++) put(v[k]);
      idle();
      wait_beats(7);
      chk(got_d.size() == 7, "R4 back-to-back count", got_d.size(), 7);
      for (int k = 0; k < 7 && k < got_d.size(); k++) begin
         chk(got_d[k] == 32'(ref_idx(v[k])), (k == 3 || k == 4 || k == 6) ?
             "R2 tie winner in order" : "R1 signed argmax in order",
             int'(got_d[k]), ref_idx(v[k]));
         chk(got_d[k][31:4] == '0, "R5 upper tdata bits zero", int'(got_d[k] >> 4), 0);
      end
   endtask

   task automatic t_batches();
      do_reset();
      batch_len = 16'd3;
      m_tready = 1'b1;
      for (int k = 0; k < 7; k++) put(pat(7, k));
      idle();
      wait_beats(7);
      chk(got_d.size() == 7, "R6 beat count", got_d.size(), 7);
      for (int k = 0; k < 7 && k < got_d.size(); k++) begin
         chk(got_l[k] == (k == 2 || k == 5), "R6 last on third beat of batch",
             int'(got_l[k]), int'(k == 2 || k == 5));
         chk(got_d[k] == 32'(k), "R1 winner position", int'(got_d[k]), k);
      end
      for (int b = 0; b < 2; b++) begin
         do_reset();
         batch_len = 16'(b);
         m_tready = 1'b1;
         for (int k = 0; k < 3; k++) put(pat(7, k + 8));
         idle();
         wait_beats(3);
         for (int k = 0; k < 3 && k < got_l.size(); k++)
            chk(got_l[k] == 1'b1, "R6 short batch length marks each beat",
                int'(got_l[k]), 1);
      end
   endtask

   task automatic t_space();
      do_reset();
      batch_len = 16'd10;
      for (int k = 0; k < 54; k++) put(pat(7, k % 16));
      idle();
      cyc(6);
      chk(space_ok == 1'b1, "R7 free equals batch", int'(space_ok), 1);
      put(pat(7, 1));
      idle();
      cyc(6);
      chk(space_ok == 1'b0, "R7 free one below batch", int'(space_ok), 0);
      batch_len = 16'd9;
      cyc(1);
      chk(space_ok == 1'b1, "R7 smaller batch fits", int'(space_ok), 1);
      m_tready = 1'b1;
      wait_beats(55);
      cyc(2);
      chk(got_d.size() == 55, "R4 drained all", got_d.size(), 55);
   endtask

   task automatic t_overflow();
      int bad;
      do_reset();
      batch_len = 16'd64;
      for (int k = 0; k < 64; k++) put(pat(7, k % 16));
      idle();
      cyc(6);
      chk(overflow == 1'b0, "R8 no drop at exactly full", int'(overflow), 0);
      chk(space_ok == 1'b0, "R7 full buffer lacks space", int'(space_ok), 0);
      put(pat(7, 15));
      put(pat(7, 15));
      idle();
      cyc(6);
      chk(overflow == 1'b1, "R8 drop raises flag", int'(overflow), 1);
      m_tready = 1'b1;
      wait_beats(64);
      cyc(10);
      chk(got_d.size() == 64, "R8 dropped writes not stored", got_d.size(), 64);
      bad = 0;
      for (int k = 0; k < got_d.size(); k++)
         if (got_d[k] != 32'(k % 16)) bad++;
      chk(bad == 0, "R8 held entries intact", bad, 0);
      chk(overflow == 1'b1, "R8 flag sticky after drain", int'(overflow), 1);
      do_reset();
      @(negedge clk);
      chk(overflow == 1'b0, "R9 reset clears flag", int'(overflow), 0);
   endtask

   initial begin
      t_reset();
      t_latency_stall();
      t_patterns();
      t_batches();
      t_space();
      t_overflow();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #4000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule